// File: doc/BRIEF.md
# Snooping Store-Through Cache Directory

This block holds the tags and valid bits for one processor's direct-mapped, store-through cache of 32-byte lines. Coherence with other processors comes from watching their stores on the shared memory bus. The block keeps two identical copies of the directory. The local copy answers the processor's fetch and store lookups. The snoop copy is compared against the line address of every store that another processor places on the bus. Snoop compares therefore never compete with local lookups for a read port.

When a foreign store hits a valid line, the block raises `steal` for exactly one cycle. In that cycle the line's valid bit is cleared in both copies, and the local lookup port is held off. Because the cache is store-through, every accepted local store is also issued on the bus. A local store never allocates a line. A line is filled by an outside controller over four 8-byte beats. The line stays invalid while the fill is in flight, and becomes valid only after the fourth beat, unless a foreign store to that same line was seen while the fill was in flight.

Top module: `scd_dir_top`

## Requirements
- R1: After reset every line is invalid, and `steal`, `rsp_valid`, `fill_busy` and `fill_done` are 0 while `lk_ready` is 1.
- R2: A lookup is accepted when `lk_valid` is 1 and `lk_ready` is 1. One cycle later `rsp_valid` is 1 and `rsp_hit` is 1 exactly when the set chosen by address bits [IDX_W+4:5] is valid and holds the tag in the bits above it.
- R3: Every accepted lookup with `lk_store`=1 drives `bus_st_valid`=1 with `bus_st_addr` equal to the lookup address, in the same cycle as its response. `rsp_store` echoes `lk_store`.
- R4: A local store that hits leaves the line valid. A local store that misses does not allocate, so a later fetch to the same address still misses.
- R5: `fill_start` with `fill_line` (the 32-byte line address) clears that set and makes `fill_busy` 1. The fill counts `fill_beat` pulses, which need not be consecutive. In the cycle after the fourth beat, `fill_done` pulses for one cycle, `fill_busy` is 0, and the line is valid.
- R6: A foreign store (`snp_valid`, `snp_line`) that hits a valid line sets `steal` to 1 for the single following cycle. After that cycle the line misses on local lookup, and a repeat of the same snoop raises no `steal`.
- R7: A foreign store to an invalid set, or to a valid set holding a different tag, never raises `steal`.
- R8: While `steal` is 1, `lk_ready` is 0 and a request presented in that cycle yields no response.
- R9: A foreign store whose line equals that of an in-flight fill, including one seen on the fourth beat, leaves the line invalid when the fill completes. It raises no `steal`. A snoop to the same set with another tag does not spoil the fill.
- R10: `fill_start` while a fill is in flight is ignored. The current fill completes unchanged and the ignored line stays a miss.
- R11: Foreign stores to the same valid line on two back-to-back cycles raise `steal` for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Local lookup request |
| lk_store | input | 1 | Lookup is a store (1) or a fetch (0) |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_ready | output | 1 | Lookup port free (0 during a steal cycle) |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_store | output | 1 | Response belongs to a store |
| bus_st_valid | output | 1 | Store-through write to the bus |
| bus_st_addr | output | ADDR_W | Byte address of that store |
| fill_start | input | 1 | Begin a line fill |
| fill_line | input | ADDR_W-5 | Line address of the fill |
| fill_beat | input | 1 | One 8-byte fill beat arrived |
| fill_busy | output | 1 | Fill in flight |
| fill_done | output | 1 | One-cycle pulse after the last beat |
| snp_valid | input | 1 | Foreign store seen on the bus |
| snp_line | input | ADDR_W-5 | Line address of the foreign store |
| steal | output | 1 | Invalidation cycle; local port stalled |

## Verification
The hardest state to reach from the ports is a foreign store landing on the very line being filled. That line is invalid throughout the fill, so the snoop copy reports no hit, and only the fill sequencer can remember that the fill has been spoiled. The stimulus injects the matching snoop on an early beat, and again on the fourth beat, which is the same cycle that writes the valid bit. It also sends a same-set, different-tag snoop that must not spoil the fill. A lookup is pushed into the single steal cycle, and a snoop is repeated back-to-back, to show that the stall and the one-cycle steal hold up.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int unsigned LINE_BYTES = 32;
  localparam int unsigned BUS_BYTES  = 8;
  localparam int unsigned FILL_BEATS = LINE_BYTES / BUS_BYTES;
  localparam int unsigned OFS_W      = $clog2(LINE_BYTES);

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_BUSY = 1'b1
  } fill_st_e;
endpackage

// File: rtl/scd_tag_array.sv
// One copy of the directory: tag store plus valid bits.
// Clear is applied after write, so an invalidation always wins a same-set collision.
module scd_tag_array #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_vld,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  logic [SETS-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [SETS];

  always_comb begin
    vld_d = vld_q;
    if (wr_en)  vld_d[wr_idx]  = wr_vld;
    if (clr_en) vld_d[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];
endmodule

// File: rtl/scd_fill_seq.sv
// Counts fill beats. It remembers whether a foreign store hit the line in flight.
module scd_fill_seq
  import scd_pkg::*;
#(
  parameter int unsigned LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] start_line,
  input  logic              beat,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  output logic              busy,
  output logic              wr_en,
  output logic [LINE_W-1:0] wr_line,
  output logic              wr_vld,
  output logic              done
);
  localparam int unsigned CNT_W = (FILL_BEATS > 1) ? $clog2(FILL_BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(FILL_BEATS - 1);

  fill_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              line_en;
  logic              poison_q, poison_d;
  logic              done_q, done_d;
  logic              snp_match;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    line_d    = line_q;
    line_en   = 1'b0;
    poison_d  = poison_q;
    done_d    = 1'b0;
    wr_en     = 1'b0;
    wr_vld    = 1'b0;
    wr_line   = line_q;
    snp_match = snp_valid && (snp_line == line_q);
    case (st_q)
      FL_IDLE: begin
        if (start) begin
          st_d     = FL_BUSY;
          cnt_d    = '0;
          line_d   = start_line;
          line_en  = 1'b1;
          poison_d = 1'b0;
          wr_en    = 1'b1;
          wr_line  = start_line;
        end
      end
      FL_BUSY: begin
        poison_d = poison_q | snp_match;
        if (beat) begin
          if (cnt_q == LAST_BEAT) begin
            wr_en  = 1'b1;
            wr_vld = !(poison_q | snp_match);
            st_d   = FL_IDLE;
            done_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = FL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= FL_IDLE;
      cnt_q    <= '0;
      poison_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      poison_q <= poison_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (line_en) line_q <= line_d;
  end

  assign busy = (st_q == FL_BUSY);
  assign done = done_q;
endmodule

// File: rtl/scd_snoop_ctl.sv
// Compares foreign stores against the snoop copy and schedules a one-cycle invalidation.
module scd_snoop_ctl #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic             dir_vld,
  input  logic [TAG_W-1:0] dir_tag,
  output logic             inv_valid,
  output logic [IDX_W-1:0] inv_idx
);
  logic             inv_q, inv_d;
  logic [IDX_W-1:0] idx_q;
  logic             idx_en;
  logic             hit_now;

  always_comb begin
    // A set already being invalidated this cycle needs no second steal.
    hit_now = snp_valid && dir_vld && (dir_tag == snp_tag)
              && !(inv_q && (idx_q == snp_idx));
    inv_d   = hit_now;
    idx_en  = hit_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_q <= 1'b0;
    else        inv_q <= inv_d;
  end

  always_ff @(posedge clk) begin
    if (idx_en) idx_q <= snp_idx;
  end

  assign inv_valid = inv_q;
  assign inv_idx   = idx_q;
endmodule

// File: rtl/scd_dir_top.sv
module scd_dir_top
  import scd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic                    lk_store,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic                    lk_ready,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_store,
  output logic                    bus_st_valid,
  output logic [ADDR_W-1:0]       bus_st_addr,
  input  logic                    fill_start,
  input  logic [ADDR_W-OFS_W-1:0] fill_line,
  input  logic                    fill_beat,
  output logic                    fill_busy,
  output logic                    fill_done,
  input  logic                    snp_valid,
  input  logic [ADDR_W-OFS_W-1:0] snp_line,
  output logic                    steal
);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned LINE_W = ADDR_W - OFS_W;
  localparam int unsigned TAG_W  = LINE_W - IDX_W;
  localparam int unsigned COPIES = 2;

  // Reset: asserts asynchronously, releases on the clock.
  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  logic [IDX_W-1:0] lk_idx, snp_idx, fw_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, snp_tag, fw_tag;
  logic [LINE_W-1:0] fw_line;
  logic fw_en, fw_vld, inv_v;

  assign lk_idx  = lk_addr[OFS_W +: IDX_W];
  assign lk_tag  = lk_addr[ADDR_W-1 -: TAG_W];
  assign snp_idx = snp_line[IDX_W-1:0];
  assign snp_tag = snp_line[LINE_W-1 -: TAG_W];
  assign fw_idx  = fw_line[IDX_W-1:0];
  assign fw_tag  = fw_line[LINE_W-1 -: TAG_W];

  // Copy 0 serves local lookups, copy 1 serves bus snoops.
  logic [IDX_W-1:0] cp_ridx [COPIES];
  logic             cp_vld  [COPIES];
  logic [TAG_W-1:0] cp_tag  [COPIES];
  assign cp_ridx[0] = lk_idx;
  assign cp_ridx[1] = snp_idx;

  for (genvar g = 0; g < COPIES; g++) begin : g_copy
    scd_tag_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .rd_idx  (cp_ridx[g]),
      .rd_vld  (cp_vld[g]),
      .rd_tag  (cp_tag[g]),
      .wr_en   (fw_en),
      .wr_idx  (fw_idx),
      .wr_tag  (fw_tag),
      .wr_vld  (fw_vld),
      .clr_en  (inv_v),
      .clr_idx (inv_idx)
    );
  end

  scd_fill_seq #(.LINE_W(LINE_W)) u_fill (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .start      (fill_start),
    .start_line (fill_line),
    .beat       (fill_beat),
    .snp_valid  (snp_valid),
    .snp_line   (snp_line),
    .busy       (fill_busy),
    .wr_en      (fw_en),
    .wr_line    (fw_line),
    .wr_vld     (fw_vld),
    .done       (fill_done)
  );

  scd_snoop_ctl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .snp_valid (snp_valid),
    .snp_idx   (snp_idx),
    .snp_tag   (snp_tag),
    .dir_vld   (cp_vld[1]),
    .dir_tag   (cp_tag[1]),
    .inv_valid (inv_v),
    .inv_idx   (inv_idx)
  );

  assign steal    = inv_v;
  assign lk_ready = !inv_v;

  // Local lookup stage
  logic accept;
  logic rsp_v_q, rsp_v_d, rsp_h_q, rsp_h_d, rsp_s_q, rsp_s_d;
  logic bst_v_q, bst_v_d, bst_en;
  logic [ADDR_W-1:0] bst_a_q;

  always_comb begin
    accept  = lk_valid && !inv_v;
    rsp_v_d = accept;
    rsp_h_d = accept && cp_vld[0] && (cp_tag[0] == lk_tag);
    rsp_s_d = accept && lk_store;
    bst_v_d = accept && lk_store;
    bst_en  = accept && lk_store;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_v_q <= 1'b0;
      rsp_h_q <= 1'b0;
      rsp_s_q <= 1'b0;
      bst_v_q <= 1'b0;
    end else begin
      rsp_v_q <= rsp_v_d;
      rsp_h_q <= rsp_h_d;
      rsp_s_q <= rsp_s_d;
      bst_v_q <= bst_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (bst_en) bst_a_q <= lk_addr;
  end

  assign rsp_valid    = rsp_v_q;
  assign rsp_hit      = rsp_h_q;
  assign rsp_store    = rsp_s_q;
  assign bus_st_valid = bst_v_q;
  assign bus_st_addr  = bst_a_q;
endmodule

// File: rtl/scd_dir_chk.sv
module scd_dir_chk (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic rsp_valid,
  input logic rsp_store,
  input logic bus_st_valid,
  input logic fill_beat,
  input logic fill_busy,
  input logic fill_done,
  input logic snp_valid,
  input logic steal
);
  // R6: a steal cycle only ever follows a foreign store
  a_r6_steal_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    steal |-> $past(snp_valid));

  // R8: nothing is accepted during a steal cycle
  a_r8_no_rsp_after_steal: assert property (@(posedge clk) disable iff (!rst_n)
    $past(steal) |-> !rsp_valid);

  // R2: every response stems from a request one cycle earlier
  a_r2_rsp_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid));

  // R3: store responses go out on the bus in the same cycle
  a_r3_store_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_store) |-> bus_st_valid);

  // R5: done follows a beat taken while busy, and the fill is then over
  a_r5_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> ($past(fill_beat && fill_busy) && !fill_busy));

  // R5: done lasts a single cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);
endmodule

bind scd_dir_top scd_dir_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .lk_valid     (lk_valid),
  .rsp_valid    (rsp_valid),
  .rsp_store    (rsp_store),
  .bus_st_valid (bus_st_valid),
  .fill_beat    (fill_beat),
  .fill_busy    (fill_busy),
  .fill_done    (fill_done),
  .snp_valid    (snp_valid),
  .steal        (steal)
);

// File: tb/sim_scd_dir_top.sv
`timescale 1ns/1ps
module sim_scd_dir_top;
  localparam int unsigned AW   = 32;
  localparam int unsigned NS   = 16;
  localparam int unsigned IW   = 4;
  localparam int unsigned OW   = 5;
  localparam int unsigned LW   = AW - OW;
  localparam int unsigned TW   = LW - IW;

  logic clk, rst_n;
  logic lk_valid, lk_store, lk_ready, rsp_valid, rsp_hit, rsp_store;
  logic [AW-1:0] lk_addr, bus_st_addr;
  logic bus_st_valid, fill_start, fill_beat, fill_busy, fill_done, snp_valid, steal;
  logic [LW-1:0] fill_line, snp_line;

  scd_dir_top #(.ADDR_W(AW), .SETS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_store(lk_store), .lk_addr(lk_addr),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_store(rsp_store),
    .bus_st_valid(bus_st_valid), .bus_st_addr(bus_st_addr), .fill_start(fill_start),
    .fill_line(fill_line), .fill_beat(fill_beat), .fill_busy(fill_busy), .fill_done(fill_done),
    .snp_valid(snp_valid), .snp_line(snp_line), .steal(steal));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Bench model of the directory
  logic          m_vld [NS];
  logic [TW-1:0] m_tag [NS];

  // Scoreboard entries: {hit, store, addr}
  logic [AW+1:0] exp_q [$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] ln(input int tag, input int idx);
    return {TW'(tag), IW'(idx)};
  endfunction

  // Monitor: pop expected responses as they appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected response", 1, 0);
      end else begin
        logic [AW+1:0] e;
        e = exp_q.pop_front();
        chk("R2 rsp_hit", rsp_hit, e[AW+1]);
        chk("R3 rsp_store", rsp_store, e[AW]);
        chk("R3 bus_st_valid", bus_st_valid, e[AW]);
        if (e[AW]) chk("R3 bus_st_addr", bus_st_addr, e[AW-1:0]);
      end
    end else if (rst_n && bus_st_valid) begin
      chk("R3 bus store without response", 1, 0);
    end
  end

  task automatic lookup(input logic [LW-1:0] line, input logic st);
    logic [AW-1:0] a;
    logic h;
    a = {line, OW'(5'd13)};
    h = m_vld[line[IW-1:0]] && (m_tag[line[IW-1:0]] == line[LW-1:IW]);
    @(negedge clk);
    lk_valid = 1'b1; lk_store = st; lk_addr = a;
    exp_q.push_back({h, st, a});
    @(negedge clk);
    lk_valid = 1'b0; lk_store = 1'b0;
  endtask

  task automatic snoop(input logic [LW-1:0] line, input string req);
    logic h;
    h = m_vld[line[IW-1:0]] && (m_tag[line[IW-1:0]] == line[LW-1:IW]);
    @(negedge clk);
    snp_valid = 1'b1; snp_line = line;
    @(negedge clk);
    snp_valid = 1'b0;
    chk(req, steal, h);
    if (h) m_vld[line[IW-1:0]] = 1'b0;
    @(negedge clk);
    chk(req, steal, 0);
  endtask

  // Fill with an optional snoop on one beat and an optional extra start on beat 0
  task automatic fill(input logic [LW-1:0] line, input int sbeat, input logic [LW-1:0] sline,
                      input logic ign_en, input logic [LW-1:0] ign_line);
    logic poison;
    poison = 1'b0;
    @(negedge clk);
    fill_start = 1'b1; fill_line = line;
    m_vld[line[IW-1:0]] = 1'b0;
    m_tag[line[IW-1:0]] = line[LW-1:IW];
    @(negedge clk);
    fill_start = 1'b0;
    chk("R5 busy during fill", fill_busy, 1);
    for (int b = 0; b < 4; b++) begin
      fill_beat = 1'b1;
      if (b == sbeat) begin
        snp_valid = 1'b1; snp_line = sline;
        if (sline == line) poison = 1'b1;
      end
      if (ign_en && b == 0) begin
        fill_start = 1'b1; fill_line = ign_line;
      end
      @(negedge clk);
      fill_beat = 1'b0; snp_valid = 1'b0; fill_start = 1'b0;
      if (b < 3) chk("R5 no early done", fill_done, 0);
      if (b == sbeat + 1) chk("R9 no steal from in-flight snoop", steal, 0);
      if (b == 1) @(negedge clk);
    end
    chk("R5 fill_done pulse", fill_done, 1);
    chk("R5 busy cleared", fill_busy, 0);
    if (sbeat == 3) chk("R9 no steal from last-beat snoop", steal, 0);
    m_vld[line[IW-1:0]] = !poison;
    @(negedge clk);
    chk("R5 done is one cycle", fill_done, 0);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; end
    rst_n = 1'b0; lk_valid = 0; lk_store = 0; lk_addr = '0;
    fill_start = 0; fill_line = '0; fill_beat = 0; snp_valid = 0; snp_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 steal", steal, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 fill_busy", fill_busy, 0);
    chk("R1 fill_done", fill_done, 0);
    chk("R1 lk_ready", lk_ready, 1);
    lookup(ln(5, 3), 0);       // R1 all lines invalid
    lookup(ln(0, 0), 0);
    lookup(ln(77, 15), 0);

    // R5 / R2 fill then hit, same set other tag misses
    fill(ln(5, 3), -5, '0, 0, '0);
    lookup(ln(5, 3), 0);
    lookup(ln(6, 3), 0);

    // R4 store hit keeps line, store miss does not allocate; R3 bus copies
    lookup(ln(5, 3), 1);
    lookup(ln(5, 3), 0);
    lookup(ln(9, 7), 1);
    lookup(ln(9, 7), 0);

    // R7 snoops that must not steal
    fill(ln(11, 9), -5, '0, 0, '0);
    snoop(ln(6, 3), "R7 other tag");
    snoop(ln(3, 12), "R7 invalid set");
    // R6 real hit, then line gone in both copies
    snoop(ln(5, 3), "R6 hit steals one cycle");
    lookup(ln(5, 3), 0);
    snoop(ln(5, 3), "R6 repeat snoop no steal");
    lookup(ln(11, 9), 0);

    // R8 lookup presented in the steal cycle is dropped
    fill(ln(5, 3), -5, '0, 0, '0);
    @(negedge clk);
    snp_valid = 1'b1; snp_line = ln(5, 3);
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R8 steal up", steal, 1);
    chk("R8 lk_ready low", lk_ready, 0);
    lk_valid = 1'b1; lk_addr = {ln(11, 9), 5'd0};
    m_vld[3] = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R8 no response", rsp_valid, 0);
    lookup(ln(11, 9), 0);
    lookup(ln(5, 3), 0);

    // R11 back-to-back snoops on one line
    fill(ln(5, 3), -5, '0, 0, '0);
    @(negedge clk);
    snp_valid = 1'b1; snp_line = ln(5, 3);
    @(negedge clk);
    chk("R11 first steal", steal, 1);
    @(negedge clk);
    snp_valid = 1'b0;
    chk("R11 single steal", steal, 0);
    @(negedge clk);
    chk("R11 stays low", steal, 0);
    m_vld[3] = 1'b0;
    lookup(ln(5, 3), 0);

    // R9 snoop on in-flight fill line
    fill(ln(20, 11), 1, ln(20, 11), 0, '0);
    lookup(ln(20, 11), 0);
    fill(ln(20, 11), 3, ln(20, 11), 0, '0);
    lookup(ln(20, 11), 0);
    fill(ln(20, 11), 2, ln(21, 11), 0, '0);
    lookup(ln(20, 11), 0);
    snoop(ln(20, 11), "R6 steal after completed fill");
    lookup(ln(20, 11), 0);

    // R10 second start during fill ignored
    fill(ln(30, 12), -5, '0, 1, ln(31, 13));
    lookup(ln(30, 12), 0);
    lookup(ln(31, 13), 0);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule